// File: doc/BRIEF.md
# Non-Maskable Trap Arbiter

This block collects the raw fault conditions behind four non-maskable traps, keeps a status flag for each, and decides which trap the processor is asked to take. The four traps sit at fixed levels above every maskable interrupt. Two of them are soft: they wait through a short sampling window, the same way ordinary interrupts do. The other two are hard: they are offered at once and hold the processor in a stall until it accepts them. Traps nest by level. An accepted trap raises the current level, and a return input drops the level back to the trap that was interrupted.

A hard trap can arrive while a higher trap is still flagged or still being serviced. That trap cannot be queued. The block drops it, pulses a device reset request, and sets a trap-reset flag that stays set. The math trap combines five fault causes into one flag. Three of those causes can be masked and two cannot. Each cause has its own sub-flag, and software must clear every sub-flag before it can clear the math flag. While the address trap is in service, the block asserts a write-block output to protect data storage.

Top module: `trap_arbiter`

## Requirements
- R1: Trap index encoding is 0 math, 1 stack, 2 address, 3 oscillator, with levels 11, 12, 13 and 14 (level = 11 + index). Among the eligible traps, the highest index is presented on `trap_idx_o` and `trap_req_level_o`, and `trap_req_o` is high. A trap is eligible when its flag is set, it is not in service, it is ready, and its level is above `cur_level_o`. When no trap is presented, `trap_req_level_o` is 0.
- R2: Indices 0 and 1 are soft. A soft trap becomes ready only after its flag has been set for two full cycles, so it can be presented no earlier than the third cycle in which the flag is visible.
- R3: Indices 2 and 3 are hard. A hard trap is ready in the first cycle its flag is visible. `stall_req_o` is high while a hard trap is presented, and it is low in the cycle in which `trap_ack_i` accepts that trap.
- R4: An accepted trap enters service, and `cur_level_o` shows its level from the next cycle on. A trap whose level is not above the current level stays flagged and waits.
- R5: `trap_ret_i` takes the highest trap out of service. `cur_level_o` then shows the next lower trap still in service, or 0 if none remains.
- R6: A hard trap whose condition arrives while its flag is clear, and while any higher trap is flagged or in service, does not set its flag. In the next cycle `reset_req_o` pulses for one cycle and `trap_reset_flag_o` sets. That flag is cleared only by `rst_n`.
- R7: Math cause bits on `math_cause_o` and `clr_cause_i` are: bit 0 accumulator A overflow, bit 1 accumulator B overflow, bit 2 catastrophic overflow, bit 3 divide by zero, bit 4 bad shift. Bits 0 to 2 are recorded only when their enable is high. Bits 3 and 4 are always recorded. A recorded cause sets the math flag.
- R8: A flag (`trap_flags_o`, bit = index) stays set until `clr_flag_i` clears it. A condition present in the same cycle wins over the clear. A clear of the math flag is ignored while any cause sub-flag is set. A sub-flag clears on its `clr_cause_i` bit.
- R9: `write_block_o` is high in every cycle in which the address trap is in service, including while a higher trap is nested on top of it.
- R10: During reset and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_a_i | input | 1 | Accumulator A overflow condition |
| ovf_b_i | input | 1 | Accumulator B overflow condition |
| ovf_cat_i | input | 1 | Catastrophic accumulator overflow condition |
| div_zero_i | input | 1 | Divide-by-zero condition |
| bad_shift_i | input | 1 | Out-of-range accumulator shift condition |
| en_ovf_a_i | input | 1 | Enable for accumulator A overflow cause |
| en_ovf_b_i | input | 1 | Enable for accumulator B overflow cause |
| en_ovf_cat_i | input | 1 | Enable for catastrophic overflow cause |
| stack_err_i | input | 1 | Stack error condition |
| addr_err_i | input | 1 | Address error condition |
| osc_fail_i | input | 1 | Oscillator failure condition |
| trap_ack_i | input | 1 | Processor accepts the presented trap |
| trap_ret_i | input | 1 | Processor returns from the current trap |
| clr_flag_i | input | 4 | Software clear, one bit per trap index |
| clr_cause_i | input | 5 | Software clear, one bit per math cause |
| trap_req_o | output | 1 | A trap is presented |
| trap_idx_o | output | 2 | Index of the presented trap |
| trap_req_level_o | output | 4 | Level of the presented trap |
| cur_level_o | output | 4 | Level of the trap in service, 0 if none |
| stall_req_o | output | 1 | Stall request for a pending hard trap |
| reset_req_o | output | 1 | One-cycle device reset request on a hard-trap conflict |
| trap_reset_flag_o | output | 1 | Sticky record of a conflict reset |
| write_block_o | output | 1 | Data writes blocked |
| trap_flags_o | output | 4 | Trap status flags |
| math_cause_o | output | 5 | Math cause sub-flags |

## Verification
A corrupted in-service set shows up on `cur_level_o` in the very next cycle. It also changes which trap is presented, because the level threshold moves. A wrong soft-trap age counter makes `trap_req_o` rise one cycle early or late after a soft flag appears. A wrong conflict decision shows up in the following cycle, either as a missing or spurious `reset_req_o` or as an address flag set when it should have been dropped. The reference model is compared on every cycle, so each of these faults is reported in the cycle it first reaches the ports.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NTRAP      = 4;
  localparam int NCAUSE     = 5;
  localparam int LVLW       = 4;
  localparam int IDXW       = $clog2(NTRAP);
  localparam int BASE_LEVEL = 11;
  localparam int SOFT_DELAY = 2;
  localparam int AGEW       = $clog2(SOFT_DELAY + 1);

  localparam int IDX_MATH  = 0;
  localparam int IDX_STACK = 1;
  localparam int IDX_ADDR  = 2;
  localparam int IDX_OSC   = 3;

  localparam logic [NTRAP-1:0] HARD_MASK = 4'b1100;

  typedef logic [NTRAP-1:0]  trap_vec_t;
  typedef logic [NCAUSE-1:0] cause_vec_t;

  function automatic logic [LVLW-1:0] lvl_of(input int idx);
    return LVLW'(BASE_LEVEL + idx);
  endfunction
endpackage

// File: rtl/trap_flags.sv
module trap_flags
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trap_vec_t  cond_i,
  input  cause_vec_t cause_cond_i,
  input  trap_vec_t  clr_flag_i,
  input  cause_vec_t clr_cause_i,
  input  trap_vec_t  in_svc_i,
  output trap_vec_t  flags_q_o,
  output trap_vec_t  flags_d_o,
  output cause_vec_t causes_o,
  output logic       reset_req_o,
  output logic       reset_flag_o
);
  trap_vec_t  flags_q, flags_d, conflict;
  cause_vec_t causes_q, causes_d;
  logic       rreq_q, rflag_q;

  // conflict: new hard event while anything above it is flagged or in service
  always_comb begin
    conflict = '0;
    for (int i = 0; i < NTRAP; i++) begin
      conflict[i] = HARD_MASK[i] & cond_i[i] & ~flags_q[i]
                  & (|((flags_q | in_svc_i) >> (i + 1)));
    end
  end

  always_comb begin
    causes_d = cause_cond_i | (causes_q & ~clr_cause_i);
    for (int i = 0; i < NTRAP; i++) begin
      logic clr_ok;
      clr_ok     = clr_flag_i[i] & ((i != IDX_MATH) | (causes_q == '0));
      flags_d[i] = (cond_i[i] & ~conflict[i]) | (flags_q[i] & ~clr_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      causes_q <= '0;
      rreq_q   <= 1'b0;
      rflag_q  <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      causes_q <= causes_d;
      rreq_q   <= |conflict;
      if (|conflict) rflag_q <= 1'b1;
    end
  end

  assign flags_q_o    = flags_q;
  assign flags_d_o    = flags_d;
  assign causes_o     = causes_q;
  assign reset_req_o  = rreq_q;
  assign reset_flag_o = rflag_q;

  assert_conflict_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|conflict) |=> (reset_req_o && reset_flag_o));
  assert_reset_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_flag_o |=> reset_flag_o);
  assert_math_clear_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[IDX_MATH] && (causes_q != '0)) |=> flags_q[IDX_MATH]);
  assert_cause_implies_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (causes_q != '0) |-> flags_q[IDX_MATH]);
endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  trap_vec_t       flags_q_i,
  input  trap_vec_t       flags_d_i,
  input  trap_vec_t       in_svc_i,
  input  logic [LVLW-1:0] cur_level_i,
  output logic            req_valid_o,
  output logic [IDXW-1:0] req_idx_o,
  output logic [LVLW-1:0] req_level_o
);
  trap_vec_t ready;

  for (genvar g = 0; g < NTRAP; g++) begin : g_ready
    if (HARD_MASK[g]) begin : g_hard
      assign ready[g] = flags_q_i[g];
    end else begin : g_soft
      logic [AGEW-1:0] age_q, age_d;
      always_comb begin
        age_d = '0;
        if (flags_q_i[g] && flags_d_i[g])
          age_d = (age_q == AGEW'(SOFT_DELAY)) ? age_q : age_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
      end
      assign ready[g] = flags_q_i[g] && (age_q == AGEW'(SOFT_DELAY));
    end
  end

  // ascending scan: the highest eligible index wins
  always_comb begin
    req_valid_o = 1'b0;
    req_idx_o   = '0;
    for (int i = 0; i < NTRAP; i++) begin
      if (ready[i] && !in_svc_i[i] && (lvl_of(i) > cur_level_i)) begin
        req_valid_o = 1'b1;
        req_idx_o   = IDXW'(i);
      end
    end
  end

  assign req_level_o = req_valid_o ? lvl_of(int'(req_idx_o)) : '0;

  assert_soft_math_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_idx_o == IDXW'(IDX_MATH)) |->
      ($past(flags_q_i[IDX_MATH]) && $past(flags_q_i[IDX_MATH], 2)));
  assert_soft_stack_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_idx_o == IDXW'(IDX_STACK)) |->
      ($past(flags_q_i[IDX_STACK]) && $past(flags_q_i[IDX_STACK], 2)));
endmodule

// File: rtl/trap_service.sv
module trap_service
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_i,
  input  logic            ret_i,
  input  logic            req_valid_i,
  input  logic [IDXW-1:0] req_idx_i,
  output trap_vec_t       in_svc_o,
  output logic [LVLW-1:0] cur_level_o
);
  trap_vec_t       svc_q, svc_d, top_bit;
  logic [IDXW-1:0] top_idx;
  logic            svc_en;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NTRAP; i++) begin
      if (svc_q[i]) top_idx = IDXW'(i);
    end
    top_bit          = '0;
    top_bit[top_idx] = |svc_q;
  end

  always_comb begin
    svc_d = svc_q;
    if (ret_i)                 svc_d = svc_d & ~top_bit;
    if (ack_i && req_valid_i)  svc_d[req_idx_i] = 1'b1;
    svc_en = ret_i | (ack_i & req_valid_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_en) svc_q <= svc_d;
  end

  assign in_svc_o    = svc_q;
  assign cur_level_o = (|svc_q) ? lvl_of(int'(top_idx)) : '0;

  assert_ack_sets_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_valid_i && !ret_i) |=> (cur_level_o == lvl_of(int'($past(req_idx_i)))));
  assert_return_pops_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ack_i && (svc_q != '0)) |=>
      ($countones(svc_q) == $countones($past(svc_q)) - 1));
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ovf_a_i,
  input  logic        ovf_b_i,
  input  logic        ovf_cat_i,
  input  logic        div_zero_i,
  input  logic        bad_shift_i,
  input  logic        en_ovf_a_i,
  input  logic        en_ovf_b_i,
  input  logic        en_ovf_cat_i,
  input  logic        stack_err_i,
  input  logic        addr_err_i,
  input  logic        osc_fail_i,
  input  logic        trap_ack_i,
  input  logic        trap_ret_i,
  input  logic [3:0]  clr_flag_i,
  input  logic [4:0]  clr_cause_i,
  output logic        trap_req_o,
  output logic [1:0]  trap_idx_o,
  output logic [3:0]  trap_req_level_o,
  output logic [3:0]  cur_level_o,
  output logic        stall_req_o,
  output logic        reset_req_o,
  output logic        trap_reset_flag_o,
  output logic        write_block_o,
  output logic [3:0]  trap_flags_o,
  output logic [4:0]  math_cause_o
);
  cause_vec_t      cause_cond;
  trap_vec_t       cond, flags_q, flags_d, in_svc;
  logic            req_valid;
  logic [IDXW-1:0] req_idx;
  logic [LVLW-1:0] req_level, cur_level;

  assign cause_cond = {bad_shift_i, div_zero_i, ovf_cat_i & en_ovf_cat_i,
                       ovf_b_i & en_ovf_b_i, ovf_a_i & en_ovf_a_i};
  assign cond       = {osc_fail_i, addr_err_i, stack_err_i, |cause_cond};

  trap_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .cond_i       (cond),
    .cause_cond_i (cause_cond),
    .clr_flag_i   (clr_flag_i),
    .clr_cause_i  (clr_cause_i),
    .in_svc_i     (in_svc),
    .flags_q_o    (flags_q),
    .flags_d_o    (flags_d),
    .causes_o     (math_cause_o),
    .reset_req_o  (reset_req_o),
    .reset_flag_o (trap_reset_flag_o)
  );

  trap_select u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_q_i   (flags_q),
    .flags_d_i   (flags_d),
    .in_svc_i    (in_svc),
    .cur_level_i (cur_level),
    .req_valid_o (req_valid),
    .req_idx_o   (req_idx),
    .req_level_o (req_level)
  );

  trap_service u_service (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (trap_ack_i),
    .ret_i       (trap_ret_i),
    .req_valid_i (req_valid),
    .req_idx_i   (req_idx),
    .in_svc_o    (in_svc),
    .cur_level_o (cur_level)
  );

  assign trap_req_o       = req_valid;
  assign trap_idx_o       = req_idx;
  assign trap_req_level_o = req_level;
  assign cur_level_o      = cur_level;
  assign stall_req_o      = req_valid & HARD_MASK[req_idx] & ~trap_ack_i;
  assign write_block_o    = in_svc[IDX_ADDR];
  assign trap_flags_o     = flags_q;

  assert_hard_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_o && trap_idx_o >= 2'd2 && !trap_ack_i) |-> stall_req_o);
  assert_write_block_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ack_i && trap_req_o && trap_idx_o == 2'd2) |=> write_block_o);
endmodule

// File: tb/test_trap_arbiter.sv
module test_trap_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf_a = 0, ovf_b = 0, ovf_cat = 0, div0 = 0, shift = 0;
  logic en_a = 0, en_b = 0, en_cat = 0;
  logic stack = 0, addr = 0, osc = 0, ack = 0, ret = 0;
  logic [3:0] clr_flag = '0;
  logic [4:0] clr_cause = '0;
  logic       d_req, d_stall, d_rreq, d_rflag, d_wb;
  logic [1:0] d_idx;
  logic [3:0] d_lvl, d_cur, d_flags;
  logic [4:0] d_cause;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit [3:0] m_flag, m_svc;
  int       m_age [2];
  bit [4:0] m_cause;
  bit       m_rreq, m_rflag;
  // model outputs
  bit       e_req, e_stall;
  int       e_idx, e_lvl, e_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_arbiter i_trap_arbiter (
    .clk(clk), .rst_n(rst_n),
    .ovf_a_i(ovf_a), .ovf_b_i(ovf_b), .ovf_cat_i(ovf_cat),
    .div_zero_i(div0), .bad_shift_i(shift),
    .en_ovf_a_i(en_a), .en_ovf_b_i(en_b), .en_ovf_cat_i(en_cat),
    .stack_err_i(stack), .addr_err_i(addr), .osc_fail_i(osc),
    .trap_ack_i(ack), .trap_ret_i(ret),
    .clr_flag_i(clr_flag), .clr_cause_i(clr_cause),
    .trap_req_o(d_req), .trap_idx_o(d_idx), .trap_req_level_o(d_lvl),
    .cur_level_o(d_cur), .stall_req_o(d_stall), .reset_req_o(d_rreq),
    .trap_reset_flag_o(d_rflag), .write_block_o(d_wb),
    .trap_flags_o(d_flags), .math_cause_o(d_cause)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  task automatic model_out();
    e_cur = 0;
    for (int i = 0; i < 4; i++) if (m_svc[i]) e_cur = 11 + i;
    e_req = 0; e_idx = 0;
    for (int i = 3; i >= 0; i--) begin
      if (!e_req && m_flag[i] && !m_svc[i] && (i >= 2 || m_age[i] >= 2) && (11 + i > e_cur)) begin
        e_req = 1; e_idx = i;
      end
    end
    e_lvl   = e_req ? 11 + e_idx : 0;
    e_stall = e_req && (e_idx >= 2) && !ack;
  endtask

  task automatic check_all();
    model_out();
    cmp("R1", "trap_req", d_req, e_req);
    if (e_req) cmp("R1", "trap_idx", d_idx, e_idx);
    cmp("R1", "req_level", d_lvl, e_lvl);
    cmp("R4", "cur_level", d_cur, e_cur);
    cmp("R3", "stall_req", d_stall, e_stall);
    cmp("R6", "reset_req", d_rreq, m_rreq);
    cmp("R6", "reset_flag", d_rflag, m_rflag);
    cmp("R9", "write_block", d_wb, m_svc[2]);
    cmp("R8", "flags", d_flags, m_flag);
    cmp("R7", "math_cause", d_cause, m_cause);
  endtask

  // one clock: compare, compute next model state, commit at the edge
  task automatic cyc();
    bit [4:0] cc, ncause;
    bit [3:0] cond, nf, nsvc;
    bit       conf;
    int       nage [2];
    #1;
    check_all();
    cc   = {shift, div0, ovf_cat & en_cat, ovf_b & en_b, ovf_a & en_a};
    cond = {osc, addr, stack, |cc};
    conf = 0;
    for (int i = 0; i < 4; i++) begin
      bit busy, cf, clrok;
      busy = 0;
      for (int j = i + 1; j < 4; j++) if (m_flag[j] || m_svc[j]) busy = 1;
      cf    = (i >= 2) && cond[i] && !m_flag[i] && busy;
      clrok = clr_flag[i] && (i != 0 || m_cause == 0);
      nf[i] = (cond[i] && !cf) || (m_flag[i] && !clrok);
      conf  = conf | cf;
    end
    ncause = cc | (m_cause & ~clr_cause);
    for (int i = 0; i < 2; i++)
      nage[i] = (m_flag[i] && nf[i]) ? ((m_age[i] >= 2) ? 2 : m_age[i] + 1) : 0;
    nsvc = m_svc;
    if (ret) begin
      for (int i = 3; i >= 0; i--) if (nsvc[i]) begin nsvc[i] = 0; break; end
    end
    if (ack && e_req) nsvc[e_idx] = 1;
    @(posedge clk);
    m_flag = nf; m_cause = ncause; m_svc = nsvc;
    m_age[0] = nage[0]; m_age[1] = nage[1];
    m_rreq = conf; m_rflag = m_rflag | conf;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic ack_when_ready(input int maxn);
    for (int k = 0; k < maxn; k++) begin
      #0; model_out();
      if (e_req) begin ack = 1; cyc(); ack = 0; return; end
      cyc();
    end
  endtask

  task automatic ret_once();
    ret = 1; cyc(); ret = 0;
  endtask

  initial begin
    m_flag = 0; m_svc = 0; m_cause = 0; m_rreq = 0; m_rflag = 0;
    m_age[0] = 0; m_age[1] = 0;
    @(negedge clk);
    cyc(); cyc();                        // R10: outputs zero while in reset
    rst_n = 1'b1;
    cyc();                               // R10: still zero after release

    // R7: masked overflow is not recorded, enabled one is
    ovf_a = 1; cyc(); ovf_a = 0; idle(2);
    en_a = 1; ovf_a = 1; cyc(); ovf_a = 0;
    idle(1);                             // R2: soft request must still be low
    ack_when_ready(5);                   // R4: enters service at level 11
    clr_flag = 4'b0001; cyc(); clr_flag = 0;   // R8: blocked, cause still set
    clr_cause = 5'b00001; cyc(); clr_cause = 0;
    clr_flag = 4'b0001; cyc(); clr_flag = 0;
    ret_once(); idle(2);                 // R5: back to level 0

    // R7: unmaskable causes with all enables low
    en_a = 0; div0 = 1; cyc(); div0 = 0; shift = 1; cyc(); shift = 0; idle(3);
    clr_cause = 5'b11000; cyc(); clr_cause = 0;
    clr_flag = 4'b0001; cyc(); clr_flag = 0; idle(2);

    // R1: stack beats math when both are ready
    en_b = 1; ovf_b = 1; stack = 1; cyc(); ovf_b = 0; stack = 0;
    ack_when_ready(5);
    clr_flag = 4'b0010; cyc(); clr_flag = 0;
    idle(3);                             // R4: math waits below level 12
    ret_once();
    ack_when_ready(5);
    clr_cause = 5'b00010; cyc(); clr_cause = 0;
    clr_flag = 4'b0001; cyc(); clr_flag = 0;
    ret_once(); idle(1);

    // R3: hard address trap stalls until accepted
    addr = 1; cyc(); addr = 0; idle(2);
    ack = 1; cyc(); ack = 0;             // R9: writes blocked from here
    osc = 1; cyc(); osc = 0;             // R4: oscillator nests above address
    ack = 1; cyc(); ack = 0;
    clr_flag = 4'b1000; cyc(); clr_flag = 0;
    ret_once(); idle(1);                 // R5: restores level 13
    clr_flag = 4'b0100; cyc(); clr_flag = 0;
    ret_once(); idle(1);

    // R8: condition beats a same-cycle clear
    stack = 1; clr_flag = 4'b0010; cyc(); stack = 0; clr_flag = 0;
    clr_flag = 4'b0010; cyc(); clr_flag = 0; idle(1);

    // R6: address trap arriving under oscillator service
    osc = 1; cyc(); osc = 0;
    ack = 1; cyc(); ack = 0;
    addr = 1; cyc(); addr = 0; idle(3);
    stack = 1; cyc(); stack = 0; idle(4); // R4: level 12 waits under 14
    clr_flag = 4'b1010; cyc(); clr_flag = 0;
    ret_once(); idle(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule